// File: doc/BRIEF.md
# Interrupt Priority Gate with Sleep Wake-Up

This block sits between a set of edge-triggered interrupt sources and a small processor core. It holds one pending flag per source and filters the flags through the per-source enables and two global masks. The first mask is a single block-everything bit. The second is a priority threshold. Each cycle it picks at most one winner and issues a one-cycle take strobe that carries the winner's ID.

Pending flags are latched on every rising edge of a source, whether or not that source is enabled at the time. A pending request is lost if software clears it before it is taken. The block also drives a wake request for a core that is waiting for an interrupt. The two masks differ here. A request held back only by the global block bit still wakes the core. A request held back by the priority threshold does not.

The threshold is a byte-wide value. Only its upper `PRIO_W` bits are compared against source priorities, and a compare field of zero turns the threshold off. A numerically lower priority value is more urgent.

Top module: `irq_prio_gate`

## Requirements
- R1: A rising edge on `src_evt[i]` sets source i's pending flag even while `src_en[i]` is low. Once the source is enabled and unmasked, it is taken on the next clock edge.
- R2: Pulsing `sw_clr[i]` while source i is pending and not yet taken discards the request, so it is never taken.
- R3: While `pri_mask` is high, no source is taken.
- R4: The threshold compare field is `base_pri[7:4]` (default widths). When that field is nonzero, a source whose priority value is greater than or equal to it is not taken.
- R5: When `base_pri[7:4]` is zero, threshold masking is off, whatever is in `base_pri[3:0]`.
- R6: Among the sources that are pending, enabled and unmasked, the lowest priority value wins. On equal priority, the lowest ID wins.
- R7: `take_vld` is high for exactly one cycle per take, with `take_id` holding the winner. The winner's pending flag clears on the same edge, so each latched event is taken once.
- R8: `wake` is high while `in_sleep` is high and some source is pending, enabled and not blocked by the threshold. This includes the case where `pri_mask` is the only thing blocking it.
- R9: A pending, enabled source that is blocked by the threshold does not raise `wake`.
- R10: If a rising edge on a source arrives on the same clock edge that takes that source, the flag stays set and the source is taken a second time.
- R11: After reset, `take_vld` and `wake` are low and all pending flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | NUM_SRC | Source event lines; a rising edge marks the source pending |
| sw_clr | input | NUM_SRC | Software clear of pending flags, one bit per source |
| src_en | input | NUM_SRC | Per-source enable |
| src_prio | input | NUM_SRC*PRIO_W | Packed priority values, source i at bits [i*PRIO_W +: PRIO_W] |
| pri_mask | input | 1 | Global block of all takes |
| base_pri | input | MASK_W | Priority threshold, compare field in the upper PRIO_W bits |
| in_sleep | input | 1 | Core is waiting for an interrupt |
| take_vld | output | 1 | One-cycle take strobe |
| take_id | output | ID_W | ID of the source being taken |
| wake | output | 1 | Wake request to the sleeping core |

## Verification
Two functions can fall in the same cycle: a take clearing a source's pending flag, and a fresh rising edge on that same source setting it. The bench sets this up by first latching the source while `pri_mask` is high. It then drops `pri_mask` in the same half-cycle that it raises the event line, so the take and the new edge meet on one clock edge. The result is judged through the scoreboard, which must see that ID taken on two consecutive cycles and no third time.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   // Resolution when a new source edge and a clear hit the same flag on one edge
   typedef enum logic {
      COLLIDE_SET_WINS = 1'b0,
      COLLIDE_CLR_WINS = 1'b1
   } collide_e;

   function automatic int unsigned id_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
   import irq_prio_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   parameter collide_e    COLLIDE = COLLIDE_SET_WINS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt,
   input  logic [NUM_SRC-1:0] sw_clr,
   input  logic [NUM_SRC-1:0] take_clr,
   output logic [NUM_SRC-1:0] pend_q
);
   logic [NUM_SRC-1:0] evt_q;
   logic [NUM_SRC-1:0] rise;
   logic [NUM_SRC-1:0] kill;
   logic [NUM_SRC-1:0] pend_d;

   assign rise = evt & ~evt_q;
   assign kill = sw_clr | take_clr;

   generate
      if (COLLIDE == COLLIDE_SET_WINS) begin : g_set_wins
         assign pend_d = (pend_q & ~kill) | rise;
      end else begin : g_clr_wins
         assign pend_d = (pend_q | rise) & ~kill;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q  <= '0;
         pend_q <= '0;
      end else begin
         evt_q  <= evt;
         pend_q <= pend_d;
      end
   end
endmodule

// File: rtl/irq_mask_filter.sv
module irq_mask_filter #(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned MASK_W  = 8
) (
   input  logic [NUM_SRC*PRIO_W-1:0] prio,
   input  logic [MASK_W-1:0]         base_pri,
   output logic [NUM_SRC-1:0]        thr_blk
);
   logic [PRIO_W-1:0] fld;
   logic              thr_on;

   assign fld    = base_pri[MASK_W-1 -: PRIO_W];
   assign thr_on = (fld != '0);

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         assign thr_blk[i] = thr_on && (prio[i*PRIO_W +: PRIO_W] >= fld);
      end
   endgenerate
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned ID_W    = 3
) (
   input  logic [NUM_SRC-1:0]        elig,
   input  logic [NUM_SRC*PRIO_W-1:0] prio,
   output logic                      hit,
   output logic [ID_W-1:0]           win_id
);
   logic [PRIO_W-1:0] best;

   always_comb begin
      hit    = 1'b0;
      win_id = '0;
      best   = '1;
      for (int i = 0; i < NUM_SRC; i++) begin
         // strict compare keeps the lower ID on a tie
         if (elig[i] && (!hit || (prio[i*PRIO_W +: PRIO_W] < best))) begin
            hit    = 1'b1;
            win_id = ID_W'(i);
            best   = prio[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/irq_prio_gate.sv
module irq_prio_gate
   import irq_prio_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned MASK_W  = 8,
   parameter collide_e    COLLIDE = COLLIDE_SET_WINS,
   localparam int unsigned ID_W   = id_width(NUM_SRC)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        src_evt,
   input  logic [NUM_SRC-1:0]        sw_clr,
   input  logic [NUM_SRC-1:0]        src_en,
   input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
   input  logic                      pri_mask,
   input  logic [MASK_W-1:0]         base_pri,
   input  logic                      in_sleep,
   output logic                      take_vld,
   output logic [ID_W-1:0]           take_id,
   output logic                      wake
);
   generate
      if (PRIO_W < 1 || PRIO_W > MASK_W) begin : g_bad_prio_w
         $error("irq_prio_gate: PRIO_W must lie in 1..MASK_W");
      end
      if (NUM_SRC < 1) begin : g_bad_num_src
         $error("irq_prio_gate: NUM_SRC must be at least 1");
      end
   endgenerate

   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] thr_blk;
   logic [NUM_SRC-1:0] ready;
   logic [NUM_SRC-1:0] elig;
   logic [NUM_SRC-1:0] take_clr;
   logic               hit;
   logic [ID_W-1:0]    win_id;
   logic               fire;

   irq_pend_bank #(.NUM_SRC(NUM_SRC), .COLLIDE(COLLIDE)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (src_evt),
      .sw_clr   (sw_clr),
      .take_clr (take_clr),
      .pend_q   (pend_q)
   );

   irq_mask_filter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .MASK_W(MASK_W)) u_mask (
      .prio     (src_prio),
      .base_pri (base_pri),
      .thr_blk  (thr_blk)
   );

   // ready: would be taken were it not for the global block bit
   assign ready = pend_q & src_en & ~thr_blk;
   assign elig  = pri_mask ? '0 : ready;

   irq_prio_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .elig   (elig),
      .prio   (src_prio),
      .hit    (hit),
      .win_id (win_id)
   );

   assign fire     = hit;
   assign take_clr = fire ? (NUM_SRC'(1) << win_id) : '0;
   assign wake     = in_sleep && (|ready);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_vld <= 1'b0;
         take_id  <= '0;
      end else begin
         take_vld <= fire;
         if (fire) take_id <= win_id;
      end
   end
endmodule

// File: rtl/irq_prio_gate_chk.sv
module irq_prio_gate_chk #(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned MASK_W  = 8,
   parameter int unsigned ID_W    = 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      take_vld,
   input logic [ID_W-1:0]           take_id,
   input logic                      wake,
   input logic                      in_sleep,
   input logic                      pri_mask,
   input logic [MASK_W-1:0]         base_pri,
   input logic [NUM_SRC*PRIO_W-1:0] src_prio,
   input logic [NUM_SRC-1:0]        src_en,
   input logic [NUM_SRC-1:0]        pend_q
);
   logic [MASK_W-1:0]         bp_prev;
   logic [NUM_SRC*PRIO_W-1:0] prio_prev;
   logic [NUM_SRC-1:0]        pend_prev;
   logic [NUM_SRC-1:0]        en_prev;
   logic [PRIO_W-1:0]         fld_prev;
   logic [PRIO_W-1:0]         taken_prio;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp_prev   <= '0;
         prio_prev <= '0;
         pend_prev <= '0;
         en_prev   <= '0;
      end else begin
         bp_prev   <= base_pri;
         prio_prev <= src_prio;
         pend_prev <= pend_q;
         en_prev   <= src_en;
      end
   end

   assign fld_prev   = bp_prev[MASK_W-1 -: PRIO_W];
   assign taken_prio = prio_prev[take_id*PRIO_W +: PRIO_W];

   assert_no_take_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pri_mask |=> !take_vld);

   assert_take_under_threshold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      take_vld |-> (fld_prev == '0) || (taken_prio < fld_prev));

   assert_take_was_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      take_vld |-> (pend_prev[take_id] && en_prev[take_id]));

   assert_wake_only_asleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> in_sleep);

   assert_no_wake_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q == '0) |-> !wake);
endmodule

bind irq_prio_gate irq_prio_gate_chk #(
   .NUM_SRC (NUM_SRC),
   .PRIO_W  (PRIO_W),
   .MASK_W  (MASK_W),
   .ID_W    (ID_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .take_vld (take_vld),
   .take_id  (take_id),
   .wake     (wake),
   .in_sleep (in_sleep),
   .pri_mask (pri_mask),
   .base_pri (base_pri),
   .src_prio (src_prio),
   .src_en   (src_en),
   .pend_q   (pend_q)
);

// File: tb/irq_prio_gate_bench.sv
module irq_prio_gate_bench;
   localparam int N  = 8;
   localparam int PW = 4;
   localparam int MW = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src_evt = '0;
   logic [N-1:0]  sw_clr = '0;
   logic [N-1:0]  src_en = '0;
   logic [N*PW-1:0] src_prio = '0;
   logic          pri_mask = 1'b0;
   logic [MW-1:0] base_pri = '0;
   logic          in_sleep = 1'b0;
   logic          take_vld;
   logic [IW-1:0] take_id;
   logic          wake;

   int n_chk = 0;
   int n_bad = 0;
   int    exp_id[$];
   string exp_tag[$];
   bit    mon_on = 1'b0;

   always #10 clk = ~clk;

   irq_prio_gate u_irq_prio_gate (
      .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .sw_clr(sw_clr),
      .src_en(src_en), .src_prio(src_prio), .pri_mask(pri_mask),
      .base_pri(base_pri), .in_sleep(in_sleep), .take_vld(take_vld),
      .take_id(take_id), .wake(wake)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic expect_take(input int id, input string tag);
      exp_id.push_back(id);
      exp_tag.push_back(tag);
   endtask

   task automatic set_prio(input int id, input int p);
      src_prio[id*PW +: PW] = PW'(p);
   endtask

   task automatic pulse(input logic [N-1:0] m);
      src_evt = src_evt | m;
      @(negedge clk);
      src_evt = src_evt & ~m;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: every take must match the head of the scoreboard
   always @(negedge clk) begin
      if (mon_on && take_vld) begin
         n_chk++;
         if (exp_id.size() == 0) begin
            n_bad++;
            $display("FAIL R7 unexpected take actual=%0d expected=none", take_id);
         end else begin
            int    e;
            string t;
            e = exp_id.pop_front();
            t = exp_tag.pop_front();
            if (int'(take_id) != e) begin
               n_bad++;
               $display("FAIL %s take_id actual=%0d expected=%0d", t, take_id, e);
            end
         end
      end
   end

   task automatic finish_run();
      check("R7 scoreboard drained", exp_id.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) set_prio(i, 8);
      idle(3);
      check("R11 take_vld in reset", take_vld, 0);
      check("R11 wake in reset", wake, 0);
      rst_n = 1'b1;
      idle(2);
      in_sleep = 1'b1;
      #1 check("R11 no pending after reset, wake", wake, 0);
      in_sleep = 1'b0;
      mon_on = 1'b1;

      // R1: event while disabled latches; enabling takes it
      pulse(8'h08);
      idle(4);
      expect_take(3, "R1");
      src_en[3] = 1'b1;
      idle(3);
      check("R1 taken once", exp_id.size(), 0);

      // R2: clear before take discards
      pulse(8'h20);
      sw_clr[5] = 1'b1;
      idle(1);
      sw_clr[5] = 1'b0;
      src_en[5] = 1'b1;
      idle(4);
      in_sleep = 1'b1;
      #1 check("R2 discarded request, no wake", wake, 0);
      in_sleep = 1'b0;

      // R3 + R8: pri_mask blocks take but still wakes
      src_en = '1;
      pri_mask = 1'b1;
      pulse(8'h04);
      idle(4);
      in_sleep = 1'b1;
      #1 check("R8 wake under pri_mask", wake, 1);
      in_sleep = 1'b0;
      expect_take(2, "R3");
      pri_mask = 1'b0;
      idle(3);
      check("R3 released take seen", exp_id.size(), 0);

      // R4 + R9: threshold field 4 blocks priority 4, passes 3
      set_prio(1, 4);
      set_prio(6, 3);
      base_pri = 8'h40;
      expect_take(6, "R4 below threshold");
      pulse(8'h42);
      idle(4);
      check("R4 blocked source not taken", exp_id.size(), 0);
      in_sleep = 1'b1;
      #1 check("R9 threshold-blocked no wake", wake, 0);
      in_sleep = 1'b0;
      expect_take(1, "R4 after raising threshold");
      base_pri = 8'h50;
      idle(3);

      // R5: zero field with low bits set disables masking
      set_prio(7, 15);
      base_pri = 8'h0F;
      expect_take(7, "R5");
      pulse(8'h80);
      idle(3);

      // R6: lowest value wins, ties to lowest ID
      pri_mask = 1'b1;
      set_prio(0, 7);
      set_prio(4, 2);
      set_prio(7, 2);
      set_prio(2, 9);
      pulse(8'h95);
      idle(1);
      expect_take(4, "R6 tie low id");
      expect_take(7, "R6 tie second");
      expect_take(0, "R6 prio 7");
      expect_take(2, "R6 prio 9");
      pri_mask = 1'b0;
      idle(6);

      // R10: new edge on the take edge re-latches
      pri_mask = 1'b1;
      pulse(8'h08);
      idle(1);
      expect_take(3, "R10 first take");
      expect_take(3, "R10 re-latched take");
      pri_mask = 1'b0;
      src_evt[3] = 1'b1;
      idle(1);
      src_evt[3] = 1'b0;
      idle(4);
      check("R10 exactly two takes", exp_id.size(), 0);

      finish_run();
   end
endmodule